// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of a synchronous DRAM read or write burst. A one-cycle start strobe captures three values: a start column, a length code and an order select. From the next cycle on, the block presents one column address per clock, together with a valid flag. The length is 1, 2, 4 or 8 beats, or an open-ended full page. The order is either a sequential count that wraps inside an aligned block, or an interleaved order formed by XOR with the beat index.

A burst ends in one of three ways. It can run to its natural end, which raises a one-cycle done flag. A stop strobe can cut it short. A new start strobe can replace it; a start is accepted on every clock, so bursts can be chained with no idle gap. The memory array, bank selection and data path are outside this block.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held and after its release, with no start, `valid` and `done` are 0.
- R2: A start sampled at a rising edge makes `valid` 1 and `colAddr` equal to `startCol` in the cycle after that edge. `startCol`, `lenCode` and `interleave` are captured at that same edge.
- R3: With `interleave`=0, beat i shows `(start & ~M) | ((start + i) & M)` for M = length-1. The bits above the block stay fixed.
- R4: With `interleave`=1, beat i shows `start ^ i`.
- R5: `lenCode` values 0, 1, 2 and 3 select 1, 2, 4 and 8 beats. After the last beat, `valid` drops to 0.
- R6: `done` is 1 for one cycle, in the cycle that follows the last beat of a finite burst. This holds when a new start coincides with that last beat. It does not hold when a stop is asserted on that beat. `done` is 0 at all other times.
- R7: With `interleave`=0, `lenCode` 4 to 7 selects full page. The address counts up by one per beat, wraps from 255 to 0, and keeps `valid` high until a stop or a start arrives.
- R8: With `interleave`=1, `lenCode` 4 to 7 behaves as a length of 8.
- R9: A stop sampled while a burst runs makes the beat shown in that cycle the last one. In the next cycle `valid` and `done` are both 0. A stop sampled while idle has no effect.
- R10: A start during a burst replaces it at once. The next cycle shows the new start column, and the old burst produces no `done`.
- R11: When start and stop are sampled at the same edge, the start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| startStb | input | 1 | Begin a new burst |
| stopStb | input | 1 | End the running burst |
| startCol | input | 8 | Start column address |
| lenCode | input | 3 | Burst length code |
| interleave | input | 1 | 1 = XOR order, 0 = sequential wrap |
| colAddr | output | 8 | Column address of the current beat |
| valid | output | 1 | `colAddr` holds a burst beat |
| done | output | 1 | Finite burst has completed |

## Verification
Every start column from 0 to 255 is run with every finite length in both orders. Comparing the two orders separates a wrapped sum from an XOR, because they differ only when a carry crosses a bit below the block edge. Odd start columns near a block edge show whether the upper bits stay fixed. A long full-page run that crosses column 255 separates a wrap inside the page from a wrap inside a block. Further sequences cover:
- a stop on the last beat;
- start and stop on the same edge;
- a start that coincides with a natural end;
- a stop while idle.

These pin down the priority and `done` rules that an ordinary burst cannot reveal.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  // Strobes from the control to the datapath.
  typedef struct packed {
    logic load;  // capture start column, length and order
    logic step;  // advance to the next beat
  } bcg_strobe_t;
endpackage

// File: rtl/bcg_datapath.sv
module bcg_datapath
  import bcg_pkg::*;
#(
  parameter int COL_W   = 8,
  parameter int LEN_W   = 3,
  parameter int MAX_LOG = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  bcg_strobe_t       strobe,
  input  logic [COL_W-1:0]  startCol,
  input  logic [LEN_W-1:0]  lenCode,
  input  logic              interleave,
  output logic [COL_W-1:0]  colAddr,
  output logic              lastBeat
);
  localparam logic [COL_W-1:0] FIN_MASK = COL_W'((1 << MAX_LOG) - 1);

  logic [COL_W-1:0] baseQ, cntQ, maskQ, maskD, sumW;
  logic             ilQ, fullQ, fullD;

  // Length decode: one mask bit per address bit that moves.
  always_comb begin
    for (int b = 0; b < COL_W; b++) maskD[b] = (b < int'(lenCode));
    fullD = 1'b0;
    if (int'(lenCode) > MAX_LOG) begin
      if (interleave) maskD = FIN_MASK;
      else begin
        maskD = '1;
        fullD = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      cntQ  <= '0;
      maskQ <= '0;
      ilQ   <= 1'b0;
      fullQ <= 1'b0;
    end else if (strobe.load) begin
      baseQ <= startCol;
      cntQ  <= '0;
      maskQ <= maskD;
      ilQ   <= interleave;
      fullQ <= fullD;
    end else if (strobe.step) begin
      cntQ  <= cntQ + 1'b1;
    end
  end

  assign sumW = baseQ + cntQ;

  // Per-bit selection: fixed, wrapped sum, or XOR.
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign colAddr[b] = maskQ[b] ? (ilQ ? (baseQ[b] ^ cntQ[b]) : sumW[b]) : baseQ[b];
  end

  assign lastBeat = !fullQ && (cntQ == maskQ);

  // R3: bits above the burst block never move between beats.
  assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> ((colAddr & ~maskQ) == ($past(colAddr) & ~$past(maskQ))));

  // R7: full page advances by exactly one, modulo the page.
  assert_page_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && fullQ) |=> (colAddr == COL_W'($past(colAddr) + 1'b1)));
endmodule

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
  import bcg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startStb,
  input  logic        stopStb,
  input  logic        lastBeat,
  output bcg_strobe_t strobe,
  output logic        valid,
  output logic        done
);
  logic activeQ, doneQ;

  always_comb begin
    strobe.load = startStb;
    strobe.step = activeQ && !startStb && !stopStb && !lastBeat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= activeQ && lastBeat && !stopStb;
      if (startStb)                activeQ <= 1'b1;
      else if (stopStb || lastBeat) activeQ <= 1'b0;
    end
  end

  assign valid = activeQ;
  assign done  = doneQ;

  // R2: a start always yields a beat in the next cycle.
  assert_start_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> valid);

  // R9/R11: a stop without a start ends the burst without a done pulse.
  assert_stop_ends_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stopStb && !startStb) |=> (!valid && !done));

  // R6: done only follows a cycle that held a beat.
  assert_done_after_beat_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(valid));

  // R6: done without a fresh start leaves the block idle.
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !$past(startStb)) |-> !valid);
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W   = 8,
  parameter int LEN_W   = 3,
  parameter int MAX_LOG = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic             stopStb,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             interleave,
  output logic [COL_W-1:0] colAddr,
  output logic             valid,
  output logic             done
);
  bcg_strobe_t strobe;
  logic        lastBeat;

  bcg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startStb (startStb),
    .stopStb  (stopStb),
    .lastBeat (lastBeat),
    .strobe   (strobe),
    .valid    (valid),
    .done     (done)
  );

  bcg_datapath #(.COL_W(COL_W), .LEN_W(LEN_W), .MAX_LOG(MAX_LOG)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .startCol   (startCol),
    .lenCode    (lenCode),
    .interleave (interleave),
    .colAddr    (colAddr),
    .lastBeat   (lastBeat)
  );
endmodule

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startStb = 1'b0;
  logic       stopStb = 1'b0;
  logic [7:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic       interleave = 1'b0;
  logic [7:0] colAddr;
  logic       valid, done;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  burst_col_gen u0 (
    .clk(clk), .rstN(rstN), .startStb(startStb), .stopStb(stopStb),
    .startCol(startCol), .lenCode(lenCode), .interleave(interleave),
    .colAddr(colAddr), .valid(valid), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expAddr(input int s, input int i, input int m, input bit il);
    if (il) return (s ^ (i & m)) & 255;
    return ((s & ~m) | ((s + i) & m)) & 255;
  endfunction

  task automatic issue(input int s, input int code, input bit il, input bit stp);
    startStb = 1'b1; stopStb = stp;
    startCol = 8'(s); lenCode = 3'(code); interleave = il;
    @(negedge clk);
    startStb = 1'b0; stopStb = 1'b0;
  endtask

  // Full finite burst: R2 R3 R4 R5 R6 R8
  task automatic runBurst(input int s, input int code, input bit il);
    int lg = (code > 3) ? 3 : code;
    int m = (1 << lg) - 1;
    @(negedge clk);
    issue(s, code, il, 1'b0);
    for (int i = 0; i <= m; i++) begin
      if (i > 0) @(negedge clk);
      chk(il ? "R4 addr" : "R3 addr", colAddr, expAddr(s, i, m, il));
      chk("R5 valid during burst", valid, 1);
      chk("R6 no done mid burst", done, 0);
    end
    @(negedge clk);
    chk("R5 valid after end", valid, 0);
    chk(code > 3 ? "R8 done after 8 beats" : "R6 done pulse", done, 1);
    @(negedge clk);
    chk("R6 done one cycle", done, 0);
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", valid, 0);
    chk("R1 done in reset", done, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 valid after reset", valid, 0);
    chk("R1 done after reset", done, 0);

    // R9: stop while idle does nothing
    stopStb = 1'b1; @(negedge clk); stopStb = 1'b0;
    chk("R9 idle stop valid", valid, 0);
    chk("R9 idle stop done", done, 0);

    // Exhaustive sweep of start columns, finite lengths, both orders
    for (int il = 0; il < 2; il++)
      for (int code = 0; code < 4; code++)
        for (int s = 0; s < 256; s++)
          runBurst(s, code, il[0]);

    // R8: interleaved with full-page codes acts as 8
    runBurst(8'h5B, 6, 1'b1);
    runBurst(8'h5B, 4, 1'b1);
    runBurst(8'hC2, 7, 1'b1);

    // R7: full page wraps 255 -> 0 and keeps going; R9 stop ends it
    @(negedge clk);
    issue(250, 4, 1'b0, 1'b0);
    for (int i = 0; i < 300; i++) begin
      if (i > 0) @(negedge clk);
      chk("R7 page addr", colAddr, (250 + i) & 255);
      chk("R7 page valid", valid, 1);
      chk("R7 no done", done, 0);
    end
    stopStb = 1'b1; @(negedge clk); stopStb = 1'b0;
    chk("R9 stop valid", valid, 0);
    chk("R9 stop no done", done, 0);

    // R9: stop on the last beat of a finite burst suppresses done
    @(negedge clk);
    issue(8'h09, 2, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      if (i > 0) @(negedge clk);
      chk("R3 addr before stop", colAddr, expAddr(8'h09, i, 3, 1'b0));
    end
    stopStb = 1'b1; @(negedge clk); stopStb = 1'b0;
    chk("R9 last-beat stop valid", valid, 0);
    chk("R9 last-beat stop done", done, 0);

    // R10 + R11: start with stop mid-burst replaces the burst
    @(negedge clk);
    issue(8'h13, 3, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      if (i > 0) @(negedge clk);
      chk("R3 addr before replace", colAddr, expAddr(8'h13, i, 7, 1'b0));
    end
    issue(8'hA5, 2, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) begin
      if (i > 0) @(negedge clk);
      chk("R10 R11 new addr", colAddr, 8'hA5 ^ i);
      chk("R11 start beats stop", valid, 1);
      chk("R10 old burst no done", done, 0);
    end
    @(negedge clk);
    chk("R10 new burst done", done, 1);
    chk("R10 idle after", valid, 0);

    // R6: start coinciding with last beat still yields done
    @(negedge clk);
    issue(8'h40, 1, 1'b0, 1'b0);
    chk("R3 beat0", colAddr, 8'h40);
    @(negedge clk);
    chk("R3 beat1", colAddr, 8'h41);
    issue(8'h7E, 0, 1'b0, 1'b0);
    chk("R6 chained done", done, 1);
    chk("R2 chained valid", valid, 1);
    chk("R2 chained addr", colAddr, 8'h7E);
    @(negedge clk);
    chk("R6 len1 done", done, 1);
    chk("R5 len1 end", valid, 0);
    @(negedge clk);
    chk("R6 done cleared", done, 0);

    finishRun();
  end
endmodule